// File: doc/BRIEF.md
# Mode-Selectable General-Purpose I/O Port

This block is one general-purpose I/O port with a parameterised number of pins (eight by default). Each pin has one bit in a data latch and a two-bit mode field. The mode decides four things for that pin: whether the pad is driven by the latch or by an on-chip peripheral, whether the output driver is on, whether the pullup is on, and whether a read returns the latch or the pad. Software uses a single-cycle write strobe and a combinational read path to reach the latch at one address and the mode word at another. Pad inputs pass through a synchroniser before any read or peripheral sees them.

Two resets reach the block. Power-on reset is asynchronous and clears everything. Manual reset is synchronous; it returns every pin to peripheral mode and keeps the latch. Standby and sleep only block register writes, so the block keeps its state through them. An emulation strap changes the power-on sequence. A small sequencer handles it with four states. ST_CLEAR is the reset state. From ST_CLEAR the sequencer goes to ST_RUN when the strap is 0. When the strap is 1, it loads input-with-pullup into every mode field and goes to ST_FILL. ST_FILL waits for the synchroniser to fill. ST_CAPTURE copies the synchronised pad levels into the latch and moves to ST_RUN. ST_RUN is the only state that accepts bus writes, and only power-on reset leaves it.

Top module: `gpio_mode_port`

## Requirements
- R1: Power-on reset with the strap at 0 clears the latch and all mode fields. `ready` is high after the first clock edge, both addresses then read 0, and no pin drives or pulls up.
- R2: Mode 2'b00 (peripheral) passes `alt_out` and `alt_oe` to `pin_out` and `pin_oe` and keeps the pullup off. A read at address 0 returns the latch bit.
- R3: Mode 2'b01 (output) drives the latch bit on `pin_out` with `pin_oe` high and the pullup off. A read returns the latch bit.
- R4: Mode 2'b10 (input, pullup) sets `pin_pu` high and `pin_oe` low. A read returns the synchronised pad level.
- R5: Mode 2'b11 (input, no pullup) sets both `pin_pu` and `pin_oe` low. A read returns the synchronised pad level.
- R6: A write at address 0 updates the latch in every mode. In input modes this is seen at the port only after the pin is switched to output.
- R7: A pad change shows at a read only after two rising clock edges. After one edge the read still shows the old level.
- R8: Manual reset sets every mode field to 2'b00 and leaves the latch unchanged.
- R9: While `standby` or `sleep` is high, bus writes to either address have no effect. Reads and the pin controls keep working.
- R10: With the strap at 1, power-on reset leads to mode word 0xAAAA (all pins input with pullup) after the first edge. `ready` rises after the fourth edge, and the latch then holds the pad levels. `ready` stays high until the next power-on reset.
- R11: Bus writes made while `ready` is low are ignored.
- R12: Address 0 holds the latch: bit n is pin n, and reads are zero-extended. Address 1 holds the mode word, and pin n uses bits [2n+1:2n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mrst_n | input | 1 | Synchronous manual reset, active low |
| standby | input | 1 | Low-power hold, blocks writes |
| sleep | input | 1 | Low-power hold, blocks writes |
| emu_strap | input | 1 | Selects the input-with-pullup power-on default |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 1 | 0 = latch, 1 = mode word |
| bus_wdata | input | 2*N_PINS | Write data |
| bus_rdata | output | 2*N_PINS | Combinational read data |
| pin_in | input | N_PINS | Pad input levels |
| pin_out | output | N_PINS | Pad output values |
| pin_oe | output | N_PINS | Pad output enables |
| pin_pu | output | N_PINS | Pad pullup enables |
| alt_out | input | N_PINS | Peripheral output values |
| alt_oe | input | N_PINS | Peripheral output enables |
| alt_in | output | N_PINS | Synchronised pad levels for peripherals |
| ready | output | 1 | Power-on sequence done |

## Verification
The hold checks for manual reset and low power assume that `mrst_n`, `standby` and `sleep` change only between clock edges. They also assume that the strap is steady from power-on reset until `ready` rises. The bench drives all of these at falling edges and holds the strap fixed across each power-on pulse. The per-pin drive checks assume that `alt_out` and `alt_oe` are settled values. The bench gives them known values for every vector.

// File: rtl/gpio_mode_port_pkg.sv
package gpio_mode_port_pkg;
    typedef enum logic [1:0] {
        PM_ALT   = 2'b00,
        PM_OUT   = 2'b01,
        PM_IN_PU = 2'b10,
        PM_IN_NP = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_FILL,
        ST_CAPTURE,
        ST_RUN
    } seq_state_e;

    localparam logic ADDR_LATCH = 1'b0;
    localparam logic ADDR_MODE  = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [N_PINS-1:0] d,
    output logic [N_PINS-1:0] q
);
    logic [N_PINS-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_seq.sv
module gpio_seq
    import gpio_mode_port_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic emu_strap,
    output logic init_modes,
    output logic capture,
    output logic ready
);
    localparam int CNT_W = $clog2(STAGES + 1);

    seq_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_CLEAR;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_FILL) cnt <= cnt + 1'b1;
            else                  cnt <= '0;
        end
    end

    always_comb begin
        state_nx   = state;
        init_modes = 1'b0;
        capture    = 1'b0;
        ready      = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                if (emu_strap) begin
                    init_modes = 1'b1;
                    state_nx   = ST_FILL;
                end else begin
                    state_nx   = ST_RUN;
                end
            end
            ST_FILL: begin
                if (cnt == CNT_W'(STAGES - 1)) state_nx = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                capture  = 1'b1;
                state_nx = ST_RUN;
            end
            ST_RUN: begin
                ready = 1'b1;
            end
            default: state_nx = ST_CLEAR;
        endcase
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int N_PINS = 8
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                mrst_n,
    input  logic                wr_ok,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [2*N_PINS-1:0] bus_wdata,
    input  logic                init_modes,
    input  logic                capture,
    input  logic [N_PINS-1:0]   sync_in,
    output logic [N_PINS-1:0]   data_q,
    output logic [2*N_PINS-1:0] mode_q
);
    localparam logic [2*N_PINS-1:0] MODES_PU = {N_PINS{2'b10}};

    logic wr_latch, wr_mode;
    assign wr_latch = wr_ok && bus_wr && (bus_addr == gpio_mode_port_pkg::ADDR_LATCH);
    assign wr_mode  = wr_ok && bus_wr && (bus_addr == gpio_mode_port_pkg::ADDR_MODE);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          data_q <= '0;
        else if (init_modes) data_q <= '0;
        else if (capture)    data_q <= sync_in;
        else if (wr_latch)   data_q <= bus_wdata[N_PINS-1:0];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          mode_q <= '0;
        else if (!mrst_n)    mode_q <= '0;
        else if (init_modes) mode_q <= MODES_PU;
        else if (wr_mode)    mode_q <= bus_wdata;
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_mode_port_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic [2*N_PINS-1:0] mode_q,
    input  logic [N_PINS-1:0]   data_q,
    input  logic [N_PINS-1:0]   sync_in,
    input  logic [N_PINS-1:0]   alt_out,
    input  logic [N_PINS-1:0]   alt_oe,
    output logic [N_PINS-1:0]   pin_out,
    output logic [N_PINS-1:0]   pin_oe,
    output logic [N_PINS-1:0]   pin_pu,
    output logic [N_PINS-1:0]   port_rd
);
    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            pin_mode_e m;
            assign m = pin_mode_e'(mode_q[2*i +: 2]);
            always_comb begin
                pin_out[i] = 1'b0;
                pin_oe[i]  = 1'b0;
                pin_pu[i]  = 1'b0;
                port_rd[i] = data_q[i];
                unique case (m)
                    PM_ALT: begin
                        pin_out[i] = alt_out[i];
                        pin_oe[i]  = alt_oe[i];
                    end
                    PM_OUT: begin
                        pin_out[i] = data_q[i];
                        pin_oe[i]  = 1'b1;
                    end
                    PM_IN_PU: begin
                        pin_pu[i]  = 1'b1;
                        port_rd[i] = sync_in[i];
                    end
                    PM_IN_NP: begin
                        port_rd[i] = sync_in[i];
                    end
                    default: ;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
    import gpio_mode_port_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int STAGES = 2,
    localparam int BUS_W = 2 * N_PINS
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              standby,
    input  logic              sleep,
    input  logic              emu_strap,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_pu,
    input  logic [N_PINS-1:0] alt_out,
    input  logic [N_PINS-1:0] alt_oe,
    output logic [N_PINS-1:0] alt_in,
    output logic              ready
);
    logic [N_PINS-1:0] sync_in;
    logic [N_PINS-1:0] data_q;
    logic [BUS_W-1:0]  mode_q;
    logic [N_PINS-1:0] port_rd;
    logic              init_modes, capture, wr_ok;

    gpio_sync #(.N_PINS(N_PINS), .STAGES(STAGES)) u_sync (
        .clk(clk), .por_n(por_n), .d(pin_in), .q(sync_in)
    );

    gpio_seq #(.STAGES(STAGES)) u_seq (
        .clk(clk), .por_n(por_n), .emu_strap(emu_strap),
        .init_modes(init_modes), .capture(capture), .ready(ready)
    );

    assign wr_ok = ready && !standby && !sleep;

    gpio_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_ok(wr_ok),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .init_modes(init_modes), .capture(capture), .sync_in(sync_in),
        .data_q(data_q), .mode_q(mode_q)
    );

    gpio_pin_ctrl #(.N_PINS(N_PINS)) u_pins (
        .mode_q(mode_q), .data_q(data_q), .sync_in(sync_in),
        .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .port_rd(port_rd)
    );

    assign alt_in    = sync_in;
    assign bus_rdata = (bus_addr == ADDR_MODE) ? mode_q : BUS_W'(port_rd);
endmodule

// File: rtl/gpio_mode_port_chk.sv
module gpio_mode_port_chk #(
    parameter int N_PINS = 8
) (
    input logic                clk,
    input logic                por_n,
    input logic                mrst_n,
    input logic                standby,
    input logic                sleep,
    input logic                ready,
    input logic [N_PINS-1:0]   data_q,
    input logic [2*N_PINS-1:0] mode_q,
    input logic [N_PINS-1:0]   pin_out,
    input logic [N_PINS-1:0]   pin_oe,
    input logic [N_PINS-1:0]   pin_pu,
    input logic [N_PINS-1:0]   alt_out,
    input logic [N_PINS-1:0]   alt_oe
);
    assert_pu_oe_excl_R4: assert property (@(posedge clk) disable iff (!por_n)
        (pin_pu & pin_oe) == '0);

    assert_ready_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        ready |=> ready);

    assert_lowpower_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
        (ready && mrst_n && (standby || sleep)) |=> ($stable(data_q) && $stable(mode_q)));

    assert_mrst_keep_R8: assert property (@(posedge clk) disable iff (!por_n)
        (ready && !mrst_n) |=> ($stable(data_q) && mode_q == '0));

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            assert_alt_pass_R2: assert property (@(posedge clk) disable iff (!por_n)
                (mode_q[2*i +: 2] == 2'b00) |-> (pin_oe[i] == alt_oe[i] && pin_out[i] == alt_out[i]));
            assert_out_drive_R3: assert property (@(posedge clk) disable iff (!por_n)
                (mode_q[2*i +: 2] == 2'b01) |-> (pin_oe[i] && pin_out[i] == data_q[i] && !pin_pu[i]));
            assert_pullup_on_R4: assert property (@(posedge clk) disable iff (!por_n)
                (mode_q[2*i +: 2] == 2'b10) |-> (pin_pu[i] && !pin_oe[i]));
            assert_float_in_R5: assert property (@(posedge clk) disable iff (!por_n)
                (mode_q[2*i +: 2] == 2'b11) |-> (!pin_pu[i] && !pin_oe[i]));
        end
    endgenerate
endmodule

bind gpio_mode_port gpio_mode_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby), .sleep(sleep),
    .ready(ready), .data_q(data_q), .mode_q(mode_q),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .alt_out(alt_out), .alt_oe(alt_oe)
);

// File: tb/gpio_mode_port_tb.sv
`timescale 1ns/1ps
module gpio_mode_port_tb;
    localparam int N = 8;
    localparam int W = 2 * N;

    logic clk = 1'b0;
    logic por_n = 1'b0, mrst_n = 1'b1, standby = 1'b0, sleep = 1'b0, emu_strap = 1'b0;
    logic bus_wr = 1'b0, bus_addr = 1'b0;
    logic [W-1:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] pin_in = '0, pin_out, pin_oe, pin_pu, alt_out = '0, alt_oe = '0, alt_in;
    logic ready;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_mode_port u_dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby), .sleep(sleep),
        .emu_strap(emu_strap), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .ready(ready)
    );

    // {mode word, latch, pad levels, alt_out, alt_oe}
    localparam logic [47:0] VEC [0:7] = '{
        {16'h5555, 8'hA5, 8'h00, 8'h00, 8'h00},
        {16'h0000, 8'h3C, 8'hFF, 8'h0F, 8'hF0},
        {16'hAAAA, 8'h00, 8'h69, 8'hFF, 8'hFF},
        {16'hFFFF, 8'hFF, 8'h96, 8'hAA, 8'h55},
        {16'hE4E4, 8'h5A, 8'hC3, 8'h33, 8'hCC},
        {16'h1B1B, 8'h81, 8'h7E, 8'hF0, 8'h0F},
        {16'h9C63, 8'h24, 8'h18, 8'h99, 8'h66},
        {16'h5500, 8'hF0, 8'h0F, 8'h0F, 8'hFF}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [W-1:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic power_on(input logic strap);
        @(negedge clk);
        emu_strap = strap; por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
    endtask

    // reference model built from R2-R5
    function automatic logic [N-1:0] m_read(logic [W-1:0] m, logic [N-1:0] d, logic [N-1:0] p);
        for (int i = 0; i < N; i++) m_read[i] = m[2*i+1] ? p[i] : d[i];
    endfunction
    function automatic logic [N-1:0] m_out(logic [W-1:0] m, logic [N-1:0] d, logic [N-1:0] a);
        for (int i = 0; i < N; i++)
            m_out[i] = (m[2*i +: 2] == 2'b00) ? a[i] : (m[2*i +: 2] == 2'b01) ? d[i] : 1'b0;
    endfunction
    function automatic logic [N-1:0] m_oe(logic [W-1:0] m, logic [N-1:0] a);
        for (int i = 0; i < N; i++)
            m_oe[i] = (m[2*i +: 2] == 2'b00) ? a[i] : (m[2*i +: 2] == 2'b01);
    endfunction
    function automatic logic [N-1:0] m_pu(logic [W-1:0] m);
        for (int i = 0; i < N; i++) m_pu[i] = (m[2*i +: 2] == 2'b10);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        // R1: plain power-on
        power_on(1'b0);
        @(negedge clk);
        chk("R1 ready", W'(ready), W'(1));
        rd(1'b0, v); chk("R1 latch read", v, '0);
        rd(1'b1, v); chk("R1 mode read", v, '0);
        chk("R1 oe", W'(pin_oe), '0);
        chk("R1 pu", W'(pin_pu), '0);

        // R2 R3 R4 R5 R12: vector table
        foreach (VEC[k]) begin
            logic [W-1:0] m;
            logic [N-1:0] d, p, ao, ae;
            {m, d, p, ao, ae} = VEC[k];
            wr(1'b1, m);
            wr(1'b0, W'(d));
            pin_in = p; alt_out = ao; alt_oe = ae;
            repeat (3) @(negedge clk);
            rd(1'b0, v); chk("R2 R3 R4 R5 R12 port read", v, W'(m_read(m, d, p)));
            rd(1'b1, v); chk("R12 mode read", v, m);
            chk("R2 R3 pin_out", W'(pin_out), W'(m_out(m, d, ao)));
            chk("R2 R3 R4 R5 pin_oe", W'(pin_oe), W'(m_oe(m, ae)));
            chk("R4 R5 pin_pu", W'(pin_pu), W'(m_pu(m)));
        end

        // R6: latch written while inputs selected
        alt_oe = '0;
        wr(1'b1, 16'hAAAA);
        pin_in = 8'h00;
        wr(1'b0, 16'h005A);
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk("R6 input read shows pad", v, 16'h0000);
        wr(1'b1, 16'h5555);
        rd(1'b0, v); chk("R6 latch kept", v, 16'h005A);
        chk("R6 drive", W'(pin_out), 16'h005A);

        // R7: synchroniser latency
        wr(1'b1, 16'hFFFF);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'hFF;
        @(negedge clk);
        rd(1'b0, v); chk("R7 one edge", v, 16'h0000);
        @(negedge clk);
        rd(1'b0, v); chk("R7 two edges", v, 16'h00FF);

        // R8: manual reset
        wr(1'b1, 16'h5555);
        wr(1'b0, 16'h00C3);
        @(negedge clk); mrst_n = 1'b0;
        @(negedge clk); mrst_n = 1'b1;
        rd(1'b1, v); chk("R8 modes cleared", v, 16'h0000);
        rd(1'b0, v); chk("R8 latch kept", v, 16'h00C3);

        // R9: standby and sleep block writes
        wr(1'b1, 16'h5555);
        standby = 1'b1;
        wr(1'b0, 16'h0011);
        wr(1'b1, 16'h0000);
        rd(1'b1, v); chk("R9 standby mode", v, 16'h5555);
        rd(1'b0, v); chk("R9 standby latch", v, 16'h00C3);
        chk("R9 standby drive", W'(pin_out), 16'h00C3);
        standby = 1'b0; sleep = 1'b1;
        wr(1'b0, 16'h0022);
        rd(1'b0, v); chk("R9 sleep latch", v, 16'h00C3);
        sleep = 1'b0;
        wr(1'b0, 16'h0044);
        rd(1'b0, v); chk("R9 write after wake", v, 16'h0044);

        // R10 R11: strap sequence
        pin_in = 8'h96;
        @(negedge clk);
        emu_strap = 1'b1; por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R10 busy after e1", W'(ready), '0);
        rd(1'b1, v); chk("R10 modes pullup", v, 16'hAAAA);
        chk("R10 pu", W'(pin_pu), 16'h00FF);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 16'h0000;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        chk("R10 busy after e3", W'(ready), '0);
        @(negedge clk);
        chk("R10 ready after e4", W'(ready), W'(1));
        rd(1'b1, v); chk("R11 busy write ignored", v, 16'hAAAA);
        wr(1'b1, 16'h5555);
        rd(1'b0, v); chk("R10 captured levels", v, 16'h0096);

        // R1: strap-free power-on after strap run clears latch
        power_on(1'b0);
        @(negedge clk);
        wr(1'b1, 16'h5555);
        rd(1'b0, v); chk("R1 latch cleared again", v, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule